// File: doc/BRIEF.md
# Priority-Ranked Clock Source Selector

This block decides which one of four reference clock inputs feeds the downstream PLL. Every input carries a loss-of-signal alarm and an out-of-frequency alarm, and each alarm type has a mask vector of its own. An input counts as healthy when none of its unmasked alarms is active. Alarm detection is done by other blocks. This one only consumes the alarm levels.

A 2-bit mode field chooses between three policies. In manual mode the input comes from either a pin code or a register code. In non-revertive automatic mode the selector stays on its current source for as long as that source remains usable. In revertive automatic mode it always moves to the best-ranked usable source. Each input has a 3-bit rank, where a smaller non-zero value means a more preferred source and zero keeps the input out of automatic choice. When zero-delay operation is enabled, the last input is set aside for the feedback path. The outputs are the chosen index, a one-cycle pulse whenever that index changes, and a flag telling the mode controller that it should fall back to holdover.

The controller is a four-state machine with these states:
- ST_MANUAL: follows the manual code.
- ST_TRACK: automatic mode, holding a usable source.
- ST_STARVED: automatic mode, with no usable source.
- ST_PARKED: the reserved mode code, where the selection is frozen.

Each cycle's mode field picks the next state:
- go_manual: mode 00 leads to ST_MANUAL.
- go_track: an automatic mode with a usable source leads to ST_TRACK.
- go_starve: an automatic mode with no usable source leads to ST_STARVED.
- go_park: mode 11 leads to ST_PARKED.

Top module: `clksel_top`

## Requirements
- R1: The mode field encodes 00 manual, 01 automatic non-revertive, 10 automatic revertive and 11 reserved. In the reserved mode the selected index is frozen, whatever the ranks and alarms do, and no_valid reports whether that frozen input is faulty.
- R2: In manual mode, use_reg_sel = 0 takes the index from pin_sel and use_reg_sel = 1 takes it from reg_sel. Index values 0 to 3 select inputs 0 to 3.
- R3: With zdm_en = 1, input 3 is never chosen automatically. A manual code of 3 is ignored, so the previous selection is kept.
- R4: Input i is faulty when (los_alarm[i] & ~los_mask[i]) | (oof_alarm[i] & ~oof_mask[i]) is 1. A mask bit of 1 removes that alarm from the decision.
- R5: The rank of input i is prio_vec[3i+2:3i]. In automatic modes a rank of 0 is never selected. A smaller non-zero rank wins, and equal ranks go to the lower index.
- R6: In revertive mode the best-ranked usable input is always the one selected. When a better-ranked input becomes usable, the selection moves back to it.
- R7: In non-revertive mode, when the previous cycle was already tracking in an automatic mode, the current input is kept while it stays usable. When it fails, the best-ranked usable input takes over, and a better input that recovers later does not take the selection back.
- R8: In automatic modes, when no input is usable, no_valid = 1 and sel_idx keeps its value. In manual mode, no_valid = 1 while the selected input is faulty.
- R9: switch_pulse is high for exactly the one cycle in which sel_idx shows a new value.
- R10: All outputs are registered and reflect the inputs sampled at the previous rising edge. During reset, sel_idx = 0, switch_pulse = 0 and no_valid = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| los_alarm | input | 4 | Loss-of-signal alarm, one bit per input |
| oof_alarm | input | 4 | Out-of-frequency alarm, one bit per input |
| los_mask | input | 4 | 1 ignores that input's loss-of-signal alarm |
| oof_mask | input | 4 | 1 ignores that input's out-of-frequency alarm |
| prio_vec | input | 12 | Packed 3-bit ranks, input i at bits [3i+2:3i] |
| mode | input | 2 | Selection policy code |
| pin_sel | input | 2 | Manual index from pins |
| reg_sel | input | 2 | Manual index from the register field |
| use_reg_sel | input | 1 | 1 selects reg_sel, 0 selects pin_sel |
| zdm_en | input | 1 | Zero-delay operation: input 3 reserved |
| sel_idx | output | 2 | Index of the chosen input |
| switch_pulse | output | 1 | One-cycle pulse on a change of sel_idx |
| no_valid | output | 1 | No usable source; request holdover |

## Verification
Several properties are checked by assertions on every cycle:
- The switch pulse agrees exactly with a change of index.
- A selection that is not flagged as invalid never points at an input that was faulty at the sampling edge.
- The automatic modes never pick a zero-ranked input, and never pick the reserved input while zero-delay operation is on.
- Revertive mode never leaves a strictly better usable input unchosen.

Other behaviour depends on history and only the bench's scenarios can show it:
- Non-revertive stickiness after a better input recovers.
- The lowest-index tie break.
- Manual source selection and the rejected manual code.
- The frozen reserved mode.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic [1:0] {
        MODE_MANUAL = 2'b00,
        MODE_NONREV = 2'b01,
        MODE_REV    = 2'b10,
        MODE_RSVD   = 2'b11
    } sel_mode_e;

    typedef enum logic [1:0] {
        ST_MANUAL  = 2'd0,
        ST_TRACK   = 2'd1,
        ST_STARVED = 2'd2,
        ST_PARKED  = 2'd3
    } sel_state_e;

endpackage

// File: rtl/clksel_qualify.sv
module clksel_qualify #(
    parameter int N_IN   = 4,
    parameter int PRIO_W = 3
) (
    input  logic [N_IN-1:0]        los_alarm,
    input  logic [N_IN-1:0]        oof_alarm,
    input  logic [N_IN-1:0]        los_mask,
    input  logic [N_IN-1:0]        oof_mask,
    input  logic [N_IN*PRIO_W-1:0] prio_vec,
    input  logic                   zdm_en,
    output logic [N_IN-1:0]        healthy,
    output logic [N_IN-1:0]        eligible
);
    // Per-input qualification: alarms after masking, then rank and reservation.
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        logic fault;
        logic reserved;
        assign fault        = (los_alarm[gi] & ~los_mask[gi]) | (oof_alarm[gi] & ~oof_mask[gi]);
        assign reserved     = zdm_en && (gi == N_IN - 1);
        assign healthy[gi]  = ~fault;
        assign eligible[gi] = ~fault && ~reserved && (prio_vec[gi*PRIO_W +: PRIO_W] != '0);
    end

endmodule

// File: rtl/clksel_rank.sv
module clksel_rank #(
    parameter int N_IN   = 4,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic [N_IN-1:0]        eligible,
    input  logic [N_IN*PRIO_W-1:0] prio_vec,
    output logic [IDX_W-1:0]       best_idx,
    output logic                   any_ok
);
    logic [PRIO_W-1:0] best_prio;

    // Strict less-than keeps the lower index on equal ranks.
    always_comb begin
        best_idx  = '0;
        best_prio = '1;
        any_ok    = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (eligible[i] && (!any_ok || (prio_vec[i*PRIO_W +: PRIO_W] < best_prio))) begin
                best_idx  = IDX_W'(i);
                best_prio = prio_vec[i*PRIO_W +: PRIO_W];
                any_ok    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/clksel_top.sv
module clksel_top
    import clksel_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        los_alarm,
    input  logic [N_IN-1:0]        oof_alarm,
    input  logic [N_IN-1:0]        los_mask,
    input  logic [N_IN-1:0]        oof_mask,
    input  logic [N_IN*PRIO_W-1:0] prio_vec,
    input  logic [1:0]             mode,
    input  logic [IDX_W-1:0]       pin_sel,
    input  logic [IDX_W-1:0]       reg_sel,
    input  logic                   use_reg_sel,
    input  logic                   zdm_en,
    output logic [IDX_W-1:0]       sel_idx,
    output logic                   switch_pulse,
    output logic                   no_valid
);
    localparam logic [IDX_W-1:0] RSVD_IDX = IDX_W'(N_IN - 1);

    logic [N_IN-1:0]  healthy;
    logic [N_IN-1:0]  eligible;
    logic [IDX_W-1:0] best_idx;
    logic             any_ok;

    sel_state_e       state_q, state_n;
    logic [IDX_W-1:0] sel_q, sel_n;
    logic             pulse_q;
    logic             nv_q, nv_n;
    logic [IDX_W-1:0] man_target;
    logic             man_blocked;

    clksel_qualify #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_qual (
        .los_alarm (los_alarm),
        .oof_alarm (oof_alarm),
        .los_mask  (los_mask),
        .oof_mask  (oof_mask),
        .prio_vec  (prio_vec),
        .zdm_en    (zdm_en),
        .healthy   (healthy),
        .eligible  (eligible)
    );

    clksel_rank #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_rank (
        .eligible (eligible),
        .prio_vec (prio_vec),
        .best_idx (best_idx),
        .any_ok   (any_ok)
    );

    assign man_target  = use_reg_sel ? reg_sel : pin_sel;
    assign man_blocked = zdm_en && (man_target == RSVD_IDX);

    // Next-state and next-selection decision.
    always_comb begin
        state_n = state_q;
        sel_n   = sel_q;
        nv_n    = 1'b0;
        unique case (sel_mode_e'(mode))
            MODE_MANUAL: begin                       // go_manual
                state_n = ST_MANUAL;
                sel_n   = man_blocked ? sel_q : man_target;
                nv_n    = ~healthy[sel_n];
            end
            MODE_NONREV: begin
                if (state_q == ST_TRACK && eligible[sel_q]) begin
                    state_n = ST_TRACK;              // go_track, hold current
                end else if (any_ok) begin
                    state_n = ST_TRACK;              // go_track, fail over
                    sel_n   = best_idx;
                end else begin
                    state_n = ST_STARVED;            // go_starve
                    nv_n    = 1'b1;
                end
            end
            MODE_REV: begin
                if (any_ok) begin
                    state_n = ST_TRACK;              // go_track, best wins
                    sel_n   = best_idx;
                end else begin
                    state_n = ST_STARVED;            // go_starve
                    nv_n    = 1'b1;
                end
            end
            MODE_RSVD: begin                         // go_park
                state_n = ST_PARKED;
                nv_n    = ~healthy[sel_q];
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_MANUAL;
        else        state_q <= state_n;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            pulse_q <= 1'b0;
            nv_q    <= 1'b1;
        end else begin
            sel_q   <= sel_n;
            pulse_q <= (sel_n != sel_q);
            nv_q    <= nv_n;
        end
    end

    assign sel_idx      = sel_q;
    assign switch_pulse = pulse_q;
    assign no_valid     = nv_q;

endmodule

// File: rtl/clksel_top_chk.sv
module clksel_top_chk #(
    parameter int N_IN   = 4,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_IN-1:0]        los_alarm,
    input logic [N_IN-1:0]        oof_alarm,
    input logic [N_IN-1:0]        los_mask,
    input logic [N_IN-1:0]        oof_mask,
    input logic [N_IN*PRIO_W-1:0] prio_vec,
    input logic [1:0]             mode,
    input logic                   zdm_en,
    input logic [IDX_W-1:0]       sel_idx,
    input logic                   switch_pulse,
    input logic                   no_valid
);
    logic [N_IN-1:0]        fault_q;
    logic [N_IN*PRIO_W-1:0] prio_q;
    logic [1:0]             mode_q;
    logic                   zdm_q;
    logic                   auto_q;
    logic                   better_exists;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
            prio_q  <= '0;
            mode_q  <= 2'b00;
            zdm_q   <= 1'b0;
        end else begin
            fault_q <= (los_alarm & ~los_mask) | (oof_alarm & ~oof_mask);
            prio_q  <= prio_vec;
            mode_q  <= mode;
            zdm_q   <= zdm_en;
        end
    end

    assign auto_q = (mode_q == 2'b01) || (mode_q == 2'b10);

    always_comb begin
        better_exists = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (!fault_q[i] && prio_q[i*PRIO_W +: PRIO_W] != '0 &&
                !(zdm_q && i == N_IN - 1) &&
                prio_q[i*PRIO_W +: PRIO_W] < prio_q[sel_idx*PRIO_W +: PRIO_W])
                better_exists = 1'b1;
        end
    end

    assert_pulse_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_idx != $past(sel_idx)) |-> switch_pulse);

    assert_pulse_only_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse |-> (sel_idx != $past(sel_idx)));

    assert_selected_healthy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !no_valid |-> !fault_q[sel_idx]);

    assert_zero_rank_skipped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_q && !no_valid) |-> (prio_q[sel_idx*PRIO_W +: PRIO_W] != '0));

    assert_zdm_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_q && zdm_q && !no_valid) |-> (sel_idx != IDX_W'(N_IN - 1)));

    assert_revert_to_best_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b10 && !no_valid) |-> !better_exists);

endmodule

bind clksel_top clksel_top_chk #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/clksel_top_tb.sv
module clksel_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  los = '0, oof = '0, lm = '0, om = '0;
    logic [11:0] prio = '0;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  pin = '0, rsel = '0;
    logic        usereg = 1'b0, zdm = 1'b0;
    logic [1:0]  sel_idx;
    logic        switch_pulse, no_valid;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    clksel_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .los_alarm(los), .oof_alarm(oof), .los_mask(lm), .oof_mask(om),
        .prio_vec(prio), .mode(mode), .pin_sel(pin), .reg_sel(rsel),
        .use_reg_sel(usereg), .zdm_en(zdm),
        .sel_idx(sel_idx), .switch_pulse(switch_pulse), .no_valid(no_valid)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_prio(int p0, int p1, int p2, int p3);
        prio = {3'(p3), 3'(p2), 3'(p1), 3'(p0)};
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check("R10 reset sel", sel_idx, 0);
        check("R10 reset pulse", switch_pulse, 0);
        check("R10 reset no_valid", no_valid, 1);
        rst_n = 1'b1;
        tick();
        check("R10 first cycle no_valid", no_valid, 0);
    endtask

    task automatic t_manual();
        mode = 2'b00; pin = 2'd2;
        tick();
        check("R2 pin select", sel_idx, 2);
        check("R9 pulse on change", switch_pulse, 1);
        tick();
        check("R9 pulse one cycle", switch_pulse, 0);
        usereg = 1'b1; rsel = 2'd1;
        tick();
        check("R2 register select", sel_idx, 1);
        los[1] = 1'b1;
        tick();
        check("R8 manual faulty", no_valid, 1);
        check("R2 manual holds faulty", sel_idx, 1);
        lm[1] = 1'b1;
        tick();
        check("R4 masked los", no_valid, 0);
        oof[1] = 1'b1;
        tick();
        check("R4 unmasked oof", no_valid, 1);
        los = '0; oof = '0; lm = '0; usereg = 1'b0; pin = 2'd0;
        tick();
        check("R2 back to input 0", sel_idx, 0);
    endtask

    task automatic t_revertive();
        set_prio(3, 1, 2, 1); mode = 2'b10;
        tick();
        check("R5 tie lowest index", sel_idx, 1);
        los[1] = 1'b1;
        tick();
        check("R6 fail over", sel_idx, 3);
        los[1] = 1'b0;
        tick();
        check("R6 revert", sel_idx, 1);
        check("R9 pulse on revert", switch_pulse, 1);
        set_prio(3, 0, 2, 1);
        tick();
        check("R5 zero rank skipped", sel_idx, 3);
    endtask

    task automatic t_nonrevertive();
        set_prio(3, 1, 2, 4); mode = 2'b01;
        tick();
        check("R7 hold current", sel_idx, 3);
        check("R9 no pulse when held", switch_pulse, 0);
        oof[3] = 1'b1;
        tick();
        check("R7 fail to best", sel_idx, 1);
        los[1] = 1'b1;
        tick();
        check("R7 next best", sel_idx, 2);
        los[1] = 1'b0;
        tick();
        check("R7 no revert", sel_idx, 2);
        oof = '0;
        tick();
    endtask

    task automatic t_zdm();
        mode = 2'b10; set_prio(2, 2, 2, 1); zdm = 1'b1;
        tick();
        check("R3 input 3 excluded", sel_idx, 0);
        mode = 2'b00; usereg = 1'b0; pin = 2'd3;
        tick();
        check("R3 manual code 3 ignored", sel_idx, 0);
        zdm = 1'b0;
        tick();
        check("R2 manual input 3", sel_idx, 3);
    endtask

    task automatic t_novalid();
        mode = 2'b10; set_prio(1, 1, 1, 1); los = 4'hF;
        tick();
        check("R8 none usable flag", no_valid, 1);
        check("R8 selection held", sel_idx, 3);
        check("R9 no pulse when starved", switch_pulse, 0);
        los = 4'b1011;
        tick();
        check("R8 recovered select", sel_idx, 2);
        check("R8 recovered flag", no_valid, 0);
    endtask

    task automatic t_reserved();
        mode = 2'b11; los = '0; set_prio(1, 2, 2, 2);
        tick();
        check("R1 reserved frozen", sel_idx, 2);
        check("R1 reserved no pulse", switch_pulse, 0);
        los[2] = 1'b1;
        tick();
        check("R1 reserved still frozen", sel_idx, 2);
        check("R1 reserved flag", no_valid, 1);
    endtask

    initial begin
        t_reset();
        t_manual();
        t_revertive();
        t_nonrevertive();
        t_zdm();
        t_novalid();
        t_reserved();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule